// File: doc/BRIEF.md
# Soft-Reset Configuration Register Slave

This block is a memory-mapped register slave on a plain 32-bit read/write bus. It holds six word registers. The word at offset 0x00 is the soft-reset control word. Every slave of this family places that word at the same offset, so one broadcast write can soft-reset all of them. The other five words hold clock-select, spare, clock-receiver and test-mux settings, and these are driven straight out as ports for the neighbouring analog and test logic.

The control word has three active bits. The first is a sticky functional-reset output for the attached peripheral. The other two are self-clearing strobes, each of which returns one class of register bits to their defaults:
- the volatile strobe clears every bit outside the retained mask;
- the retained strobe clears every bit inside the retained mask.

The parameter `NV_MASK` selects, per word, which bits are retained. A write lands on the clock edge. The strobe bit written at one edge clears the registers at the following edge. Read data is combinational: it follows `rdEn` and `addr` within the same cycle, and it is zero whenever `rdEn` is low.

Top module: `sreset_cfg_slave`

## Requirements
- R1: At reset, `periphRst` is 1 and every register field is 0, so offset 0x00 reads `{BLOCK_ID, 16'h0100}`.
- R2: A read of offset 0x00 returns `BLOCK_ID` in bits 31:16 and the peripheral reset state in bit 8. All other bits read 0, including the two strobe bits 1 and 0.
- R3: A write to offset 0x00 loads `periphRst` from write bit 8. The value holds until the next write to offset 0x00, and neither strobe changes it.
- R4: Writing 1 to bit 1 of offset 0x00 clears, at the next clock edge, every bit outside the retained mask, and leaves the retained bits as they were. With the default mask, the retained bits are offset 0x04 bits 3:0 and offset 0x0C bits 31:16.
- R5: Writing 1 to bit 0 of offset 0x00 clears, at the next clock edge, every retained bit, and leaves all other bits as they were.
- R6: Each strobe is a single-cycle pulse. Writing both strobe bits together clears every register field.
- R7: A register write issued in the same cycle that a strobe is clearing loses to the strobe for the bits that strobe clears.
- R8: Offset 0x04 bits 1:0 drive `pllSel0` and bits 3:2 drive `pllSel1`. Bits 31:4 read 0 and ignore writes.
- R9: Offsets 0x08 (`laneClkSel`) and 0x0C (`spareBits`) store and return all 32 written bits.
- R10: Offset 0x10 bits 13:0 drive `rxCtrl` bit for bit, and bits 31:14 read 0. The layout is: 13 rdiff enable, 12 pull-up enable, 11:10 and 5:4 receive mode, 9:8 and 3:2 termination, 7 and 1 hysteresis enable, 6 and 0 drive enable; the upper group is the N side and the lower group is the P side.
- R11: Offset 0x14 drives test channel 1 (select in bits 17:13, enable in bit 12) and test channel 0 (select in bits 11:7, enable in bit 6). Bits 5:0 and 31:18 read 0.
- R12: Writes to word offsets 0x18 and above change nothing. Reads of those offsets return 0, and `rdData` is 0 while `rdEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| wrEn | input | 1 | Write request for this cycle |
| rdEn | input | 1 | Read request for this cycle |
| addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data |
| periphRst | output | 1 | Sticky functional reset to the peripheral |
| pllSel0 | output | 2 | Reference clock select 0 |
| pllSel1 | output | 2 | Reference clock select 1 |
| laneClkSel | output | 32 | Lane clock mux selection word |
| spareBits | output | 32 | Spare control word |
| rxCtrl | output | 14 | Clock receiver controls |
| tmuxSel0 | output | 5 | Test channel 0 select |
| tmuxEn0 | output | 1 | Test channel 0 enable |
| tmuxSel1 | output | 5 | Test channel 1 select |
| tmuxEn1 | output | 1 | Test channel 1 enable |

## Verification
The bench writes words that mix retained and volatile bits, fires each strobe on its own and then both together, and checks which bits survive. A design that used the mask the wrong way round would wipe the spare word's upper half on a volatile strobe instead of the lower half. The bench also issues a register write in the cycle a strobe is clearing; a design that gave the write priority would keep the new value. Writes of all ones to every word expose reserved bits that are stored or read back, and writes to offsets past the last word catch an address decode that aliases onto a real register. Repeated control-word writes with bit 8 toggling catch a peripheral reset that the strobes disturb or that fails to hold.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

  localparam int NREG = 6;
  localparam int DW   = 32;

  // Strobes from the control section to the register datapath
  typedef struct packed {
    logic [NREG-1:0] wrSel;
    logic [NREG-1:0] rdSel;
    logic            volClr;
    logic            nvClr;
  } regStrobe_t;

  // Bits that software can store in each word
  function automatic logic [DW-1:0] wrMask(input int idx);
    case (idx)
      1:       wrMask = 32'h0000_000F;
      2:       wrMask = 32'hFFFF_FFFF;
      3:       wrMask = 32'hFFFF_FFFF;
      4:       wrMask = 32'h0000_3FFF;
      5:       wrMask = 32'h0003_FFC0;
      default: wrMask = 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/scfg_ctrl.sv
module scfg_ctrl
  import scfg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-3:0] wordIdx,
  input  logic              wdPeriph,
  input  logic              wdVol,
  input  logic              wdNv,
  output regStrobe_t        strb,
  output logic              periphRst
);

  localparam int IDXW = ADDR_W - 2;

  logic [NREG-1:0] hit;
  logic            volPulse;
  logic            nvPulse;
  logic            ctlWr;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_dec
      assign hit[i] = (wordIdx == IDXW'(i));
    end
  endgenerate

  assign ctlWr = wrEn && hit[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periphRst <= 1'b1;
      volPulse  <= 1'b0;
      nvPulse   <= 1'b0;
    end else begin
      volPulse <= ctlWr && wdVol;
      nvPulse  <= ctlWr && wdNv;
      if (ctlWr) periphRst <= wdPeriph;
    end
  end

  always_comb begin
    strb.wrSel  = wrEn ? hit : '0;
    strb.rdSel  = rdEn ? hit : '0;
    strb.volClr = volPulse;
    strb.nvClr  = nvPulse;
  end

endmodule

// File: rtl/scfg_regs.sv
module scfg_regs
  import scfg_pkg::*;
#(
  parameter logic [15:0]               BLOCK_ID = 16'h5C21,
  parameter logic [NREG-1:0][DW-1:0]   NV_MASK  = '0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [DW-1:0]              wrData,
  input  regStrobe_t                 strb,
  input  logic                       periphRst,
  output logic [NREG-1:0][DW-1:0]    wordQ,
  output logic [DW-1:0]              rdData
);

  localparam logic [DW-1:0] RST_VAL = '0;

  assign wordQ[0] = {BLOCK_ID, 7'b0, periphRst, 8'b0};

  generate
    for (genvar i = 1; i < NREG; i++) begin : g_word
      localparam logic [DW-1:0] WM = wrMask(i);
      logic [DW-1:0] nextW;

      always_comb begin
        nextW = wordQ[i];
        if (strb.wrSel[i]) nextW = (wordQ[i] & ~WM) | (wrData & WM);
        if (strb.volClr)   nextW = (nextW & NV_MASK[i])  | (RST_VAL & ~NV_MASK[i]);
        if (strb.nvClr)    nextW = (nextW & ~NV_MASK[i]) | (RST_VAL & NV_MASK[i]);
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) wordQ[i] <= RST_VAL;
        else       wordQ[i] <= nextW;
      end
    end
  endgenerate

  always_comb begin
    rdData = '0;
    for (int k = 0; k < NREG; k++) begin
      if (strb.rdSel[k]) rdData = rdData | wordQ[k];
    end
  end

endmodule

// File: rtl/sreset_cfg_slave.sv
module sreset_cfg_slave
  import scfg_pkg::*;
#(
  parameter int                      ADDR_W   = 8,
  parameter logic [15:0]             BLOCK_ID = 16'h5C21,
  parameter logic [NREG-1:0][DW-1:0] NV_MASK  = {32'h0, 32'h0, 32'hFFFF_0000,
                                                 32'h0, 32'h0000_000F, 32'h0}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              periphRst,
  output logic [1:0]        pllSel0,
  output logic [1:0]        pllSel1,
  output logic [31:0]       laneClkSel,
  output logic [31:0]       spareBits,
  output logic [13:0]       rxCtrl,
  output logic [4:0]        tmuxSel0,
  output logic              tmuxEn0,
  output logic [4:0]        tmuxSel1,
  output logic              tmuxEn1
);

  regStrobe_t                 strb;
  logic [NREG-1:0][DW-1:0]    wordQ;
  logic [1:0]                 unusedAddrLow;

  assign unusedAddrLow = addr[1:0];

  scfg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .wordIdx  (addr[ADDR_W-1:2]),
    .wdPeriph (wrData[8]),
    .wdVol    (wrData[1]),
    .wdNv     (wrData[0]),
    .strb     (strb),
    .periphRst(periphRst)
  );

  scfg_regs #(.BLOCK_ID(BLOCK_ID), .NV_MASK(NV_MASK)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .wrData   (wrData),
    .strb     (strb),
    .periphRst(periphRst),
    .wordQ    (wordQ),
    .rdData   (rdData)
  );

  assign pllSel0    = wordQ[1][1:0];
  assign pllSel1    = wordQ[1][3:2];
  assign laneClkSel = wordQ[2];
  assign spareBits  = wordQ[3];
  assign rxCtrl     = wordQ[4][13:0];
  assign tmuxEn0    = wordQ[5][6];
  assign tmuxSel0   = wordQ[5][11:7];
  assign tmuxEn1    = wordQ[5][12];
  assign tmuxSel1   = wordQ[5][17:13];

endmodule

// File: rtl/scfg_chk.sv
module scfg_chk
  import scfg_pkg::*;
#(
  parameter int                      ADDR_W  = 8,
  parameter logic [NREG-1:0][DW-1:0] NV_MASK = '0
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic [31:0]       rdData,
  input logic              periphRst,
  input logic [31:0]       laneClkSel,
  input logic [31:0]       spareBits,
  input regStrobe_t        strb
);

  logic [ADDR_W-3:0] idx;
  logic              ctlWr;
  assign idx   = addr[ADDR_W-1:2];
  assign ctlWr = wrEn && (idx == '0);

  // R3
  periph_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlWr |=> periphRst == $past(wrData[8]));

  // R3
  periph_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWr |=> $stable(periphRst));

  // R4
  vol_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.volClr |=> ((spareBits & ~NV_MASK[3]) == 0) && ((laneClkSel & ~NV_MASK[2]) == 0));

  // R4
  vol_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.volClr && !strb.nvClr && !strb.wrSel[3])
      |=> (spareBits & NV_MASK[3]) == $past(spareBits & NV_MASK[3]));

  // R5
  nv_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.nvClr |=> (spareBits & NV_MASK[3]) == 0);

  // R6
  vol_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.volClr && !(ctlWr && wrData[1])) |=> !strb.volClr);

  // R6
  nv_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.nvClr && !(ctlWr && wrData[0])) |=> !strb.nvClr);

  // R2
  ctl_read_fmt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && idx == '0) |-> (rdData[15:9] == 0) && (rdData[7:0] == 0));

  // R12
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && idx >= (ADDR_W-2)'(NREG)) |-> rdData == 0);

  // R12
  idle_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> rdData == 0);

endmodule

bind sreset_cfg_slave scfg_chk #(.ADDR_W(ADDR_W), .NV_MASK(NV_MASK)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .addr      (addr),
  .wrData    (wrData),
  .rdData    (rdData),
  .periphRst (periphRst),
  .laneClkSel(laneClkSel),
  .spareBits (spareBits),
  .strb      (strb)
);

// File: tb/sreset_cfg_slave_tb.sv
`timescale 1ns/1ps
module sreset_cfg_slave_tb;

  localparam logic [15:0] BID = 16'h5C21;

  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        periphRst, tmuxEn0, tmuxEn1;
  logic [1:0]  pllSel0, pllSel1;
  logic [31:0] laneClkSel, spareBits;
  logic [13:0] rxCtrl;
  logic [4:0]  tmuxSel0, tmuxSel1;

  always #2 clk = ~clk;

  sreset_cfg_slave u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .periphRst(periphRst),
    .pllSel0(pllSel0), .pllSel1(pllSel1), .laneClkSel(laneClkSel),
    .spareBits(spareBits), .rxCtrl(rxCtrl), .tmuxSel0(tmuxSel0),
    .tmuxEn0(tmuxEn0), .tmuxSel1(tmuxSel1), .tmuxEn1(tmuxEn1)
  );

  // Reference model, from the requirements
  logic [31:0] mWord [1:5];
  logic        mPeriph = 1'b1;
  logic        mVolPend = 1'b0;
  logic        mNvPend = 1'b0;
  int          vectors = 0;
  int          errors = 0;
  bit          done = 1'b0;
  string       phase = "R1 reset";

  function automatic logic [31:0] storeMask(input int i);
    case (i)
      1: return 32'h0000_000F;   // R8
      2: return 32'hFFFF_FFFF;   // R9
      3: return 32'hFFFF_FFFF;   // R9
      4: return 32'h0000_3FFF;   // R10
      5: return 32'h0003_FFC0;   // R11
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] keepMask(input int i);
    case (i)
      1: return 32'h0000_000F;   // R4 retained bits
      3: return 32'hFFFF_0000;
      default: return 32'h0;
    endcase
  endfunction

  initial for (int i = 1; i <= 5; i++) mWord[i] = '0;

  always @(posedge clk) begin
    int wi;
    bit newVol, newNv;
    wi = int'(addr[7:2]);
    newVol = 1'b0;
    newNv  = 1'b0;
    if (!rstN) begin
      for (int i = 1; i <= 5; i++) mWord[i] = '0;
      mPeriph = 1'b1; mVolPend = 1'b0; mNvPend = 1'b0;
    end else begin
      if (wrEn && wi >= 1 && wi <= 5)
        mWord[wi] = (mWord[wi] & ~storeMask(wi)) | (wrData & storeMask(wi));
      if (wrEn && wi == 0) begin
        mPeriph = wrData[8];
        newVol = wrData[1];
        newNv  = wrData[0];
      end
      for (int i = 1; i <= 5; i++) begin
        if (mVolPend) mWord[i] = mWord[i] & keepMask(i);
        if (mNvPend)  mWord[i] = mWord[i] & ~keepMask(i);
      end
      mVolPend = newVol;
      mNvPend  = newNv;
    end
  end

  function automatic logic [31:0] modelRead();
    int wi;
    wi = int'(addr[7:2]);
    if (!rdEn) return 32'h0;
    if (wi == 0) return {BID, 7'b0, mPeriph, 8'b0};
    if (wi <= 5) return mWord[wi];
    return 32'h0;
  endfunction

  function automatic string readTag();
    int wi;
    wi = int'(addr[7:2]);
    if (!rdEn || wi > 5) return "R12";
    case (wi)
      0: return "R2";
      1: return "R8";
      2, 3: return "R9";
      4: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] t=%0t actual=%h expected=%h", req, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!done) begin
      chk(readTag(), rdData, modelRead());
      chk("R3",  {31'b0, periphRst}, {31'b0, mPeriph});
      chk("R8",  {28'b0, pllSel1, pllSel0}, {28'b0, mWord[1][3:0]});
      chk("R9",  laneClkSel, mWord[2]);
      chk("R9",  spareBits, mWord[3]);
      chk("R10", {18'b0, rxCtrl}, {18'b0, mWord[4][13:0]});
      chk("R11", {14'b0, tmuxSel1, tmuxEn1, tmuxSel0, tmuxEn0, 6'b0},
                 {14'b0, mWord[5][17:6], 6'b0});
    end
  end

  task automatic cyc(input bit we, input bit re, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = we; rdEn = re; addr = a; wrData = d;
  endtask

  task automatic fillAll(input logic [31:0] d);
    for (int i = 1; i <= 5; i++) cyc(1'b1, 1'b0, 8'(i * 4), d);
  endtask

  task automatic readAll();
    for (int i = 0; i <= 7; i++) cyc(1'b0, 1'b1, 8'(i * 4), 32'h0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #1 rstN = 1'b0;
    phase = "R1 reset";
    readAll();
    @(negedge clk); rstN = 1'b1;
    readAll();

    phase = "R8 R9 R10 R11 all ones";
    fillAll(32'hFFFF_FFFF);
    readAll();
    phase = "R9 pattern";
    fillAll(32'hA5C3_3C5A);
    readAll();

    phase = "R3 periph toggle";
    cyc(1'b1, 1'b1, 8'h00, 32'h0000_0000);
    cyc(1'b0, 1'b1, 8'h00, 32'h0);
    cyc(1'b1, 1'b1, 8'h00, 32'hFFFF_FEFC);
    cyc(1'b0, 1'b1, 8'h00, 32'h0);

    phase = "R4 volatile strobe";
    fillAll(32'hFFFF_FFFF);
    cyc(1'b1, 1'b0, 8'h00, 32'h0000_0002);
    cyc(1'b0, 1'b0, 8'h00, 32'h0);
    readAll();

    phase = "R7 strobe beats write";
    fillAll(32'h1234_5678);
    cyc(1'b1, 1'b0, 8'h00, 32'h0000_0102);
    cyc(1'b1, 1'b0, 8'h0C, 32'hFFFF_FFFF);
    cyc(1'b1, 1'b0, 8'h0C, 32'h0F0F_0F0F);
    readAll();

    phase = "R5 retained strobe";
    fillAll(32'hFFFF_FFFF);
    cyc(1'b1, 1'b0, 8'h00, 32'h0000_0101);
    cyc(1'b1, 1'b0, 8'h04, 32'h0000_000F);
    readAll();

    phase = "R6 both strobes";
    fillAll(32'hDEAD_BEEF);
    cyc(1'b1, 1'b1, 8'h00, 32'h0000_0003);
    cyc(1'b0, 1'b1, 8'h00, 32'h0);
    cyc(1'b0, 1'b1, 8'h0C, 32'h0);
    readAll();

    phase = "R12 unmapped";
    fillAll(32'h0BAD_F00D);
    cyc(1'b1, 1'b1, 8'h18, 32'hFFFF_FFFF);
    cyc(1'b1, 1'b1, 8'h1C, 32'hFFFF_FFFF);
    cyc(1'b1, 1'b1, 8'hFC, 32'hFFFF_FFFF);
    cyc(1'b0, 1'b0, 8'h08, 32'h0);
    readAll();

    phase = "R4 R5 R6 R7 random mix";
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      a = 8'(($urandom % 8) * 4);
      if (a == 8'h00 && ($urandom % 3) != 0) a = 8'h0C;
      cyc(1'($urandom), 1'($urandom), a | 8'($urandom % 4), $urandom);
    end
    cyc(1'b0, 1'b0, 8'h00, 32'h0);
    @(negedge clk);
    #2;
    finishRun();
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

endmodule